// File: doc/BRIEF.md
# Edge-Triggered Lock Event Interrupt Gatherer

This block collects lock and lost-lock events from two clock-path controllers (called A and B) and merges them into a single active-high interrupt line. Each of the four event sources owns a sticky flag that is set only when the sampled source level changes from false to true, so a condition that stays asserted raises exactly one event. A per-source enable register shares the flag register's bit layout. The interrupt line is high while any flag whose enable bit is set is itself set.

A host reaches the block through a simple register port: a write strobe, a two-bit address, four bits of write data and a combinational read-data bus. Flags cannot be written directly. To acknowledge an event the host writes 0 to the matching enable bit, which wipes the flag at once, then writes 1 to arm the source again. Because a flag survives after its source has dropped, the host confirms the present condition through two read-only live-level registers.

Top module: `irq_gather`

## Requirements
- R1: After reset the enable register reads 0, the flag register reads 0, and `irq_o` is low.
- R2: Enable (address 0, read/write) and flag (address 1, read-only) registers use bit 3 = A lost-lock, bit 2 = A lock, bit 1 = B lost-lock and bit 0 = B lock. Read bits above the defined fields read 0.
- R3: While a source's enable bit is 1, a false-to-true change of that source sets its flag. The flag and `irq_o` show it after the second rising clock edge following the change: one edge samples the source and one edge latches the flag.
- R4: A source held true sets its flag only once, and the flag stays set after the source returns to false.
- R5: `irq_o` is high exactly when at least one bit of (enable AND flag) is 1.
- R6: A write of 0 to an enable bit clears the matching flag on that same clock edge, even if a rising edge of the source is detected in that cycle. A later write of 1 re-arms the source, and the next rising edge sets the flag again.
- R7: While an enable bit is 0, rising edges of its source are not latched. This includes an edge detected in the same cycle in which the enable bit is written to 1.
- R8: Writes to addresses 1, 2 and 3 change no register.
- R9: Address 2 reads {A lost-lock, A lock} and address 3 reads {B lost-lock, B lock} in bits 1:0. These are the source levels sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctla_lock_i | input | 1 | Controller A lock level |
| ctla_lost_i | input | 1 | Controller A lost-lock level |
| ctlb_lock_i | input | 1 | Controller B lock level |
| ctlb_lost_i | input | 1 | Controller B lost-lock level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench holds a source high for many cycles. A design that latches on level rather than on edge would set the flag again right after it has been cleared. It also lowers a source before the host services it, to catch a flag that follows the live level. A source edge is placed in the same cycle as a clearing write and in the same cycle as a re-arming write. A design with the wrong priority would leave a stale flag set and keep the interrupt line asserted. Writes to the read-only addresses check that the flags cannot be cleared or forced by a stray write, and a long random run compares every read and the interrupt line against a bench model.

// File: rtl/irq_gather_pkg.sv
// Shared constants for the interrupt gatherer: source count, bit
// positions of each event source, and the register address map.
// Assumes exactly two controllers with one lock and one lost-lock
// event each.
package irq_gather_pkg;
    localparam int unsigned SRC_N  = 4;
    localparam int unsigned ADDR_W = 2;

    // Bit positions shared by the enable and flag registers.
    localparam int unsigned BIT_B_LOCK = 0;
    localparam int unsigned BIT_B_LOST = 1;
    localparam int unsigned BIT_A_LOCK = 2;
    localparam int unsigned BIT_A_LOST = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_FLAGS  = 2'd1,
        REG_LIVE_A = 2'd2,
        REG_LIVE_B = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_edge_cell.sv
// One event source: samples the raw level each clock, detects a
// false-to-true change between consecutive samples, and holds a sticky
// flag. Assumes clr_i is a single-cycle strobe raised when the host
// writes 0 to this source's enable bit. A clear wins over a
// simultaneous edge.
module irq_edge_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic en_i,
    input  logic clr_i,
    output logic live_o,
    output logic flag_o
);
    logic samp_q;
    logic prev_q;
    logic rise;

    // Two-stage sampler: the current sample and the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= src_i;
            prev_q <= samp_q;
        end
    end

    // A rising change is a sample that is high while the previous one was low.
    assign rise = samp_q & ~prev_q;

    // Sticky flag: a clear has priority, otherwise latch an enabled rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (clr_i)
            flag_o <= 1'b0;
        else if (en_i && rise)
            flag_o <= 1'b1;
    end

    assign live_o = samp_q;

    // R3: a flag only ever turns on after an enabled rising sample.
    a_r3_set_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(flag_o) && flag_o) |-> $past(samp_q && !prev_q && en_i));

    // R4: once set, a flag holds until a clear strobe.
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_o) && !$past(clr_i)) |-> flag_o);

    // R6: a clear strobe always leaves the flag low on the next cycle.
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);

    // R7: a disabled source never shows a set flag.
    a_r7_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !flag_o);
endmodule

// File: rtl/irq_host_regs.sv
// Host register port: holds the enable register, produces per-source
// clear strobes when an enable bit is written 0, and multiplexes read
// data. Assumes read data is consumed combinationally in the same cycle
// as the address. Writes outside the enable address are dropped.
module irq_host_regs
    import irq_gather_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SRC_N-1:0]  wdata_i,
    input  logic [SRC_N-1:0]  flags_i,
    input  logic [SRC_N-1:0]  live_i,
    output logic [SRC_N-1:0]  enable_o,
    output logic [SRC_N-1:0]  clear_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned HALF_N = SRC_N / 2;

    logic en_write;

    assign en_write = we_i && (reg_addr_e'(addr_i) == REG_ENABLE);

    // Enable register: the only host-writable state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_o <= '0;
        else if (en_write)
            enable_o <= wdata_i;
    end

    // Clear strobes: every enable bit written 0 wipes its flag.
    assign clear_o = en_write ? ~wdata_i : '0;

    // Read multiplexer with zero fill above the defined fields.
    always_comb begin
        rdata_o = '0;
        unique case (reg_addr_e'(addr_i))
            REG_ENABLE: rdata_o[SRC_N-1:0]  = enable_o;
            REG_FLAGS:  rdata_o[SRC_N-1:0]  = flags_i;
            REG_LIVE_A: rdata_o[HALF_N-1:0] = live_i[SRC_N-1:HALF_N];
            REG_LIVE_B: rdata_o[HALF_N-1:0] = live_i[HALF_N-1:0];
            default:    rdata_o = '0;
        endcase
    end

    // R8: the enable register changes only through a write to its address.
    a_r8_enable_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_write) |-> (enable_o == $past(enable_o)));
endmodule

// File: rtl/irq_gather.sv
// Top level: maps the four controller event levels onto their bit
// positions, builds one edge cell per source, and drives the interrupt
// line from the enabled flags. Assumes source levels are already
// synchronous to clk.
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctla_lock_i,
    input  logic              ctla_lost_i,
    input  logic              ctlb_lock_i,
    input  logic              ctlb_lost_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [SRC_N-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [SRC_N-1:0] src_vec;
    logic [SRC_N-1:0] enable;
    logic [SRC_N-1:0] clear;
    logic [SRC_N-1:0] flags;
    logic [SRC_N-1:0] live;

    // Place each event level at its register bit position.
    always_comb begin
        src_vec             = '0;
        src_vec[BIT_A_LOST] = ctla_lost_i;
        src_vec[BIT_A_LOCK] = ctla_lock_i;
        src_vec[BIT_B_LOST] = ctlb_lost_i;
        src_vec[BIT_B_LOCK] = ctlb_lock_i;
    end

    // One edge-detect and sticky-flag cell per event source.
    for (genvar g = 0; g < SRC_N; g++) begin : g_cell
        irq_edge_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_vec[g]),
            .en_i   (enable[g]),
            .clr_i  (clear[g]),
            .live_o (live[g]),
            .flag_o (flags[g])
        );
    end

    irq_host_regs #(.DATA_W(DATA_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .flags_i  (flags),
        .live_i   (live),
        .enable_o (enable),
        .clear_o  (clear),
        .rdata_o  (reg_rdata_o)
    );

    // Interrupt line: any flag whose source is enabled.
    assign irq_o = |(enable & flags);

    // R6: writing all enables to 0 leaves the interrupt line low.
    a_r6_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we_i) && $past(reg_addr_i) == REG_ENABLE && $past(reg_wdata_i) == '0)
        |-> !irq_o);
endmodule

// File: tb/test_irq_gather.sv
// Self-checking bench: directed corner cases followed by a seeded
// random run, all compared against a cycle model kept in the bench.
module test_irq_gather;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_lock = 1'b0, a_lost = 1'b0, b_lock = 1'b0, b_lost = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Bench model state.
    logic [3:0] m_samp = '0, m_prev = '0, m_en = '0, m_flag = '0;

    always #5 clk = ~clk;

    irq_gather i_irq_gather (
        .clk(clk), .rst_n(rst_n),
        .ctla_lock_i(a_lock), .ctla_lost_i(a_lost),
        .ctlb_lock_i(b_lock), .ctlb_lost_i(b_lost),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {4'b0, m_en};
            2'd1:    return {4'b0, m_flag};
            2'd2:    return {6'b0, m_samp[3], m_samp[2]};
            default: return {6'b0, m_samp[1], m_samp[0]};
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_en & m_flag);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive stimulus, advance the model at the edge, settle at negedge.
    task automatic tick(input logic we, input logic [1:0] a, input logic [3:0] wd,
                        input logic [3:0] s);
        logic [3:0] rise, clr;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        {a_lost, a_lock, b_lost, b_lock} = s;
        @(posedge clk);
        rise = m_samp & ~m_prev;
        clr = (we && a == 2'd0) ? ~wd : 4'b0;
        m_flag = (m_flag | (rise & m_en)) & ~clr;
        if (we && a == 2'd0) m_en = wd;
        m_prev = m_samp;
        m_samp = s;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
        check(req, reg_rdata, exp_read(a));
    endtask

    initial begin
        #1500000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [3:0] s;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd("R1", 2'd0, 8'h00);
        rd("R1", 2'd1, 8'h00);
        check("R1", {7'b0, irq}, 8'h00);

        // R3 / R2 / R9: enable all, raise A lock, flag after the second edge.
        tick(1'b1, 2'd0, 4'hF, 4'b0000);
        tick(1'b0, 2'd1, 4'h0, 4'b0100);
        rd("R3", 2'd1, 8'h00);
        rd("R9", 2'd2, 8'h01);
        tick(1'b0, 2'd1, 4'h0, 4'b0100);
        rd("R3", 2'd1, 8'h04);
        rd("R2", 2'd0, 8'h0F);
        check("R5", {7'b0, irq}, 8'h01);

        // R4: holding and then dropping the source keeps the flag.
        repeat (4) tick(1'b0, 2'd1, 4'h0, 4'b0100);
        repeat (3) tick(1'b0, 2'd1, 4'h0, 4'b0000);
        rd("R4", 2'd1, 8'h04);

        // R6: writing 0 to enable bit 2 clears its flag at once.
        tick(1'b1, 2'd0, 4'hB, 4'b0000);
        rd("R6", 2'd1, 8'h00);
        check("R6", {7'b0, irq}, 8'h00);

        // R7: an edge while disabled is dropped.
        repeat (3) tick(1'b0, 2'd1, 4'h0, 4'b0100);
        rd("R7", 2'd1, 8'h00);
        repeat (2) tick(1'b0, 2'd1, 4'h0, 4'b0000);

        // R7: an edge detected in the very cycle the enable is written 1.
        tick(1'b0, 2'd1, 4'h0, 4'b0100);
        tick(1'b1, 2'd0, 4'hF, 4'b0100);
        tick(1'b0, 2'd1, 4'h0, 4'b0100);
        rd("R7", 2'd1, 8'h00);

        // R6: an edge coinciding with the clearing write resolves to cleared.
        tick(1'b0, 2'd1, 4'h0, 4'b0101);
        tick(1'b1, 2'd0, 4'hE, 4'b0101);
        rd("R6", 2'd1, 8'h00);

        // R6: re-arm and a later rising edge sets the flag again.
        tick(1'b1, 2'd0, 4'hF, 4'b0100);
        tick(1'b0, 2'd1, 4'h0, 4'b0101);
        tick(1'b0, 2'd1, 4'h0, 4'b0101);
        rd("R6", 2'd1, 8'h01);

        // R8: writes to read-only addresses change nothing.
        tick(1'b1, 2'd1, 4'h0, 4'b0101);
        tick(1'b1, 2'd2, 4'hF, 4'b0101);
        tick(1'b1, 2'd3, 4'hF, 4'b0101);
        rd("R8", 2'd1, 8'h01);
        rd("R8", 2'd0, 8'h0F);

        // Random run against the model.
        s = 4'b0101;
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [1:0] a;
            logic [3:0] wd;
            for (int b = 0; b < 4; b++)
                if ($urandom_range(3) == 0) s[b] = ~s[b];
            we = ($urandom_range(4) == 0);
            a = 2'($urandom_range(3));
            wd = ($urandom_range(2) == 0) ? 4'($urandom_range(15)) : 4'hF;
            tick(we, a, wd, s);
            check("R5", {7'b0, irq}, {7'b0, exp_irq()});
            reg_addr = 2'($urandom_range(3));
            #1;
            check("R2", reg_rdata, exp_read(reg_addr));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule